// File: doc/BRIEF.md
# Ethernet Frame Tag Inserter

This block sits in a byte-wide packet path in front of a WAN encapsulator. It can add up to two 4-byte tags to each Ethernet frame that passes through it. The leading tag goes in front of the destination address. The trailing tag goes right after the source address, so it follows input byte 12. Anything that already sat at that point, such as an existing VLAN tag, moves further back in the frame and is never overwritten.

Both tag values and their enables are static configuration inputs. They are changed only between frames. Input and output are streams with valid/ready handshakes and start/end-of-frame markers. While a tag byte is being produced the block holds its input ready low, so no input byte is lost or repeated. The frame check sequence is not touched here; a later stage recomputes it.

Top module: `tag_inserter`

## Requirements
- R1: After reset, out_valid is 0 and, with no input offered, in_ready is 1.
- R2: With both enables low, every frame leaves byte for byte as it came in, with the same start and end markers.
- R3: With pre_en high, the four bytes of pre_tag (bits 31:24 first, bits 7:0 last) are emitted before the first input byte. out_sof is on the first tag byte and is no longer on the original first byte.
- R4: With post_en high and a frame longer than 12 bytes, the four bytes of post_tag (bits 31:24 first) are emitted right after input byte 12. Bytes 13 onward follow unchanged and in order.
- R5: A frame of 12 bytes or fewer gets no trailing tag, whatever post_en is.
- R6: With both enables high and a frame longer than 12 bytes, the output frame is 8 bytes longer than the input. out_eof stays on the last original byte.
- R7: While tag bytes are being produced, in_ready is low. A frame start that is offered while pre_en is high is first held off. Every input byte appears exactly once at the output.
- R8: While out_valid is high and out_ready is low, out_data, out_sof and out_eof hold their values and in_ready is low.
- R9: A one-byte frame (start and end on the same byte) with pre_en high leaves as the four tag bytes followed by that byte. out_sof is on the first tag byte and out_eof is on the original byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_en | input | 1 | Enables the tag placed in front of the destination address |
| pre_tag | input | 32 | Value of the leading tag, most significant byte emitted first |
| post_en | input | 1 | Enables the tag placed after the source address |
| post_tag | input | 32 | Value of the trailing tag, most significant byte emitted first |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte on this edge |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |

## Verification
If the byte counter is wrong, the trailing tag ends up at the wrong offset. The scoreboard catches that on the first misplaced output byte, inside the same frame. If the "leading tag already sent" flag is wrong, the tag appears twice or not at all, or out_sof lands on the wrong byte. The mismatch shows within the first five output bytes of the affected frame. If the tag index or the state is wrong, the tag bytes come out in the wrong order or an input byte is dropped. The queue comparison finds this on the first wrong byte, and the frame-length property flags it at that frame's last byte.

// File: rtl/tagins_pkg.sv
package tagins_pkg;
  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2
  } tagins_state_e;
endpackage

// File: rtl/tagins_tagsel.sv
// Picks one byte of a tag word, lane 0 being the most significant byte.
module tagins_tagsel #(
  parameter int TAG_BYTES = 4,
  parameter int IDX_W     = 2
) (
  input  logic [8*TAG_BYTES-1:0] tag,
  input  logic [IDX_W-1:0]       idx,
  output logic [7:0]             byte_o
);
  logic [7:0] lane [TAG_BYTES];

  for (genvar k = 0; k < TAG_BYTES; k++) begin : g_lane
    assign lane[k] = tag[8*(TAG_BYTES-1-k) +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int k = 0; k < TAG_BYTES; k++) begin
      if (idx == IDX_W'(k)) byte_o = lane[k];
    end
  end
endmodule

// File: rtl/tagins_fcnt.sv
// Counts accepted bytes of the current frame, saturating at SPLIT.
module tagins_fcnt #(
  parameter int SPLIT = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic in_sof,
  input  logic in_eof,
  output logic at_split
);
  localparam int CW = $clog2(SPLIT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] base;

  assign base     = in_sof ? '0 : cnt;
  assign at_split = (base == CW'(SPLIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (accept) begin
      if (in_eof)                  cnt <= '0;
      else if (base < CW'(SPLIT))  cnt <= base + 1'b1;
      else                         cnt <= base;
    end
  end
endmodule

// File: rtl/tagins_ctrl.sv
module tagins_ctrl
  import tagins_pkg::*;
#(
  parameter int TAG_BYTES = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_ok,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             pre_en,
  input  logic             post_en,
  input  logic             at_split,
  output logic             in_ready,
  output logic             accept,
  output logic [IDX_W-1:0] tag_idx,
  output tagins_state_e    state,
  output logic             emit_valid,
  output logic             emit_sof,
  output logic             emit_eof,
  output logic             emit_from_in
);
  logic pre_sent;
  logic start_pre;
  logic last_idx;

  assign start_pre = (state == ST_PASS) && in_valid && in_sof && pre_en && !pre_sent;
  assign in_ready  = load_ok && (state == ST_PASS) && !start_pre;
  assign accept    = in_valid && in_ready;
  assign last_idx  = (tag_idx == IDX_W'(TAG_BYTES - 1));

  always_comb begin
    emit_valid   = 1'b0;
    emit_sof     = 1'b0;
    emit_eof     = 1'b0;
    emit_from_in = 1'b1;
    case (state)
      ST_PRE: begin
        emit_valid   = 1'b1;
        emit_sof     = (tag_idx == '0);
        emit_from_in = 1'b0;
      end
      ST_POST: begin
        emit_valid   = 1'b1;
        emit_from_in = 1'b0;
      end
      default: begin
        emit_valid = accept;
        emit_sof   = in_sof && !pre_sent;
        emit_eof   = in_eof;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PASS;
      tag_idx  <= '0;
      pre_sent <= 1'b0;
    end else begin
      case (state)
        ST_PRE, ST_POST: begin
          if (load_ok) begin
            if (last_idx) begin
              tag_idx <= '0;
              state   <= ST_PASS;
              if (state == ST_PRE) pre_sent <= 1'b1;
            end else begin
              tag_idx <= tag_idx + 1'b1;
            end
          end
        end
        default: begin
          if (start_pre) begin
            state <= ST_PRE;
          end else if (accept) begin
            if (in_sof || in_eof) pre_sent <= 1'b0;
            if (!in_eof && at_split && post_en) state <= ST_POST;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tagins_oreg.sv
module tagins_oreg (
  input  logic       clk,
  input  logic       rst,
  input  logic       out_ready,
  input  logic       emit_valid,
  input  logic [7:0] emit_data,
  input  logic       emit_sof,
  input  logic       emit_eof,
  output logic       load_ok,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  assign load_ok = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else if (load_ok) begin
      out_valid <= emit_valid;
      out_data  <= emit_data;
      out_sof   <= emit_sof;
      out_eof   <= emit_eof;
    end
  end
endmodule

// File: rtl/tag_inserter.sv
module tag_inserter
  import tagins_pkg::*;
#(
  parameter int TAG_BYTES  = 4,
  parameter int ADDR_BYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pre_en,
  input  logic [8*TAG_BYTES-1:0] pre_tag,
  input  logic                  post_en,
  input  logic [8*TAG_BYTES-1:0] post_tag,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_data,
  input  logic                  in_sof,
  input  logic                  in_eof,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [7:0]            out_data,
  output logic                  out_sof,
  output logic                  out_eof
);
  localparam int SPLIT = 2 * ADDR_BYTES;
  localparam int IDX_W = (TAG_BYTES > 1) ? $clog2(TAG_BYTES) : 1;

  logic             load_ok;
  logic             accept;
  logic             at_split;
  logic [IDX_W-1:0] tag_idx;
  tagins_state_e    state;
  logic             emit_valid;
  logic             emit_sof;
  logic             emit_eof;
  logic             emit_from_in;
  logic [7:0]       pre_byte;
  logic [7:0]       post_byte;
  logic [7:0]       emit_data;

  tagins_fcnt #(.SPLIT(SPLIT)) u_fcnt (
    .clk(clk), .rst(rst), .accept(accept),
    .in_sof(in_sof), .in_eof(in_eof), .at_split(at_split)
  );

  tagins_ctrl #(.TAG_BYTES(TAG_BYTES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .load_ok(load_ok),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .pre_en(pre_en), .post_en(post_en), .at_split(at_split),
    .in_ready(in_ready), .accept(accept), .tag_idx(tag_idx), .state(state),
    .emit_valid(emit_valid), .emit_sof(emit_sof), .emit_eof(emit_eof),
    .emit_from_in(emit_from_in)
  );

  tagins_tagsel #(.TAG_BYTES(TAG_BYTES), .IDX_W(IDX_W)) u_pre_sel (
    .tag(pre_tag), .idx(tag_idx), .byte_o(pre_byte)
  );

  tagins_tagsel #(.TAG_BYTES(TAG_BYTES), .IDX_W(IDX_W)) u_post_sel (
    .tag(post_tag), .idx(tag_idx), .byte_o(post_byte)
  );

  assign emit_data = emit_from_in ? in_data :
                     (state == ST_PRE) ? pre_byte : post_byte;

  tagins_oreg u_oreg (
    .clk(clk), .rst(rst), .out_ready(out_ready),
    .emit_valid(emit_valid), .emit_data(emit_data),
    .emit_sof(emit_sof), .emit_eof(emit_eof),
    .load_ok(load_ok), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );
endmodule

// File: rtl/tagins_checker.sv
module tagins_checker #(
  parameter int TAG_BYTES = 4,
  parameter int SPLIT     = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       pre_en,
  input logic       post_en,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sof,
  input logic       in_eof,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof
);
  logic        in_hs, out_hs, out_open;
  logic [15:0] in_len, in_len_done, out_len, out_total, want_len;

  assign in_hs     = in_valid && in_ready;
  assign out_hs    = out_valid && out_ready;
  assign out_total = out_sof ? 16'd1 : out_len + 16'd1;
  assign want_len  = in_len_done + (pre_en ? 16'(TAG_BYTES) : 16'd0)
                   + ((post_en && in_len_done > 16'(SPLIT)) ? 16'(TAG_BYTES) : 16'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_len      <= '0;
      in_len_done <= '0;
      out_len     <= '0;
      out_open    <= 1'b0;
    end else begin
      if (in_hs) begin
        if (in_eof) begin
          in_len_done <= in_sof ? 16'd1 : in_len + 16'd1;
          in_len      <= '0;
        end else begin
          in_len <= in_sof ? 16'd1 : in_len + 16'd1;
        end
      end
      if (out_hs) begin
        if (out_eof) begin
          out_len  <= '0;
          out_open <= 1'b0;
        end else begin
          out_len  <= out_total;
          out_open <= 1'b1;
        end
      end
    end
  end

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
    out_hs && out_eof |-> out_total == want_len); // R6
  AST_SOF_OPENS: assert property (@(posedge clk) disable iff (rst)
    out_hs && out_sof |-> !out_open); // R3
  AST_BODY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    out_hs && !out_sof |-> out_open); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)); // R8
  AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R7
endmodule

bind tag_inserter tagins_checker #(.TAG_BYTES(TAG_BYTES), .SPLIT(2*ADDR_BYTES)) u_chk (
  .clk(clk), .rst(rst), .pre_en(pre_en), .post_en(post_en),
  .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_eof(in_eof),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eof(out_eof)
);

// File: tb/tag_inserter_tb.sv
`timescale 1ns/1ps
module tag_inserter_tb;
  typedef struct {
    logic [7:0] d;
    logic       s;
    logic       e;
    string      req;
  } item_t;

  item_t exp_q[$];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_en = 1'b0, post_en = 1'b0;
  logic [31:0] pre_tag = 32'hA1B2C3D4, post_tag = 32'h81000E05;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid, out_sof, out_eof;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit held = 0;
  logic [7:0] held_d;

  always #10 clk = ~clk;

  tag_inserter u_dut (
    .clk(clk), .rst(rst), .pre_en(pre_en), .pre_tag(pre_tag),
    .post_en(post_en), .post_tag(post_tag),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push_exp(logic [7:0] d, logic s, logic e, string req);
    item_t it;
    it.d = d; it.s = s; it.e = e; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic drive_byte(logic [7:0] b, logic s, logic e, bit expect_hold);
    repeat ($urandom_range(0, 1)) @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
    #5;
    if (expect_hold) check(!in_ready, "R7", "frame start held for leading tag", in_ready, 0);
    while (!in_ready) begin
      @(negedge clk);
      #5;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_frame(int len, logic [7:0] seed, string req);
    logic [7:0] b;
    if (pre_en)
      for (int k = 0; k < 4; k++) push_exp(pre_tag[8*(3-k) +: 8], k == 0, 1'b0, "R3");
    for (int i = 0; i < len; i++) begin
      b = seed + 8'(i * 3);
      push_exp(b, (i == 0) && !pre_en, i == len - 1, req);
      if (i == 11 && len > 12 && post_en)
        for (int k = 0; k < 4; k++) push_exp(post_tag[8*(3-k) +: 8], 1'b0, 1'b0, "R4");
    end
    for (int i = 0; i < len; i++)
      drive_byte(seed + 8'(i * 3), i == 0, i == len - 1, (i == 0) && pre_en);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Monitor: chooses out_ready for the coming edge, then scores the handshake.
  always @(negedge clk) begin
    if (!rst) begin
      if (held) check(out_valid && out_data == held_d, "R8", "stalled byte held", out_data, held_d);
      out_ready = ($urandom_range(0, 3) != 0);
      held = 0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected output byte", out_data, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(out_data == it.d, it.req, "data", out_data, it.d);
          check({out_sof, out_eof} == {it.s, it.e}, it.req, "sof/eof", {out_sof, out_eof}, {it.s, it.e});
        end
      end else if (out_valid) begin
        held = 1;
        held_d = out_data;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired, pending=%0d expected=0", exp_q.size());
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    @(negedge clk);

    send_frame(20, 8'h10, "R2");
    send_frame(5, 8'h40, "R2");
    drain();

    pre_en = 1'b1;
    send_frame(14, 8'h20, "R3");
    send_frame(1, 8'h77, "R9");
    send_frame(6, 8'h30, "R7");
    drain();

    pre_en = 1'b0; post_en = 1'b1;
    send_frame(20, 8'h50, "R4");
    send_frame(13, 8'h60, "R4");
    send_frame(12, 8'h70, "R5");
    send_frame(3, 8'h90, "R5");
    drain();

    pre_en = 1'b1;
    send_frame(30, 8'hA0, "R6");
    send_frame(12, 8'hB0, "R5");
    send_frame(1, 8'hC0, "R9");
    send_frame(16, 8'hD0, "R6");
    drain();

    done = 1;
    finish_run();
  end
endmodule